// File: doc/BRIEF.md
# Successive-Approximation Converter Control Logic

This block is the digital half of a successive-approximation analog-to-digital converter. Software programs one 8-bit control/status word holding the input channel, a clock-rate bit and an enable bit. Any write with the enable bit set starts a conversion. The block then closes the sample switch for a fixed number of conversion-clock periods. After that it runs a binary search on a 10-bit trial code that drives an external DAC. In each step it reads a one-bit comparator that says whether the held input is at or above the DAC level.

The conversion clock is a clock-enable derived from the system clock, at one half or one quarter of its rate. When the last bit has been decided, the result is split across a high and a low data register. An end-of-conversion flag is raised at the same time, and a read of the high data register clears it. The multiplexer, hold capacitor, DAC and comparator are outside the block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the status word reads 0x00, the sample switch is open, the trial code is 0 and both data registers read 0.
- R2: The status word reads as {flag, rate, enable, 0, 0, channel[2:0]} from bit 7 down to bit 0. Writes to bits 7, 4 and 3 are ignored. The channel output follows the written channel field, so 3'b010 selects input 2.
- R3: A write with enable (bit 5) set clears the flag and closes the sample switch from the next cycle. The switch stays closed for exactly 4 conversion-clock periods.
- R4: Rate bit (bit 6) at 1 makes the conversion clock the system clock divided by 2, and at 0 divided by 4. The flag rises 14 conversion periods (28 or 56 cycles) after the starting write is sampled.
- R5: When the sample switch opens, the trial code is 0x200, with only the most significant bit set.
- R6: At each conversion-clock step the bit under test is kept if the comparator input is 1 and cleared if it is 0, and the next lower bit is then set. For an input whose 8 upper result bits are 0xB2, the upper bytes of the trial codes run 0x80, 0xC0, 0xA0, 0xB0, 0xB8, 0xB4, 0xB2, 0xB3.
- R7: When the flag rises, the high data register holds result bits 9:2 and the low data register holds result bits 1:0 in its bits 1:0, with zeros above. Both registers hold their values at all other times.
- R8: The flag stays set until a pulse on the high-data-read input clears it on the next edge. A completion in the same cycle as such a pulse wins over the clear.
- R9: A write with enable clear starts nothing and aborts a conversion in progress. The switch is opened at once, the flag is not set afterwards, and the data registers and the trial code are left unchanged.
- R10: A write with enable set during a conversion restarts it from the sampling phase, with the timing of R3 and R4 counted from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Status-word write strobe |
| csr_wdata | input | 8 | Status-word write data |
| csr_rdata | output | 8 | Status-word read value |
| dat_hi_rd | input | 1 | Pulse marking a read of the high data register |
| dat_hi | output | 8 | High data register, result bits 9:2 |
| dat_lo | output | 8 | Low data register, result bits 1:0 in bits 1:0 |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| chan_sel | output | 3 | Analog multiplexer channel select |
| samp_en | output | 1 | Sample switch closed when 1 |
| dac_code | output | 10 | Trial code to the DAC |

## Verification
Let E0 be the edge that samples the start write, and D the divide ratio. The switch closes after E0 and opens after edge E0+4D, which also loads 0x200. Each later trial code appears D cycles after the previous one, and the flag and data registers change after edge E0+14D. The bench drives and samples on falling edges and counts falling edges from E0. It checks each output both at the last count before it is due and at the count where it is due. Abort and restart cases reuse the same count, taken from the write that matters.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int CH_W = 3;
  localparam int BIT_FLAG = 7;
  localparam int BIT_RATE = 6;
  localparam int BIT_EN = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_SEARCH = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int DMAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int CW = (DMAX > 2) ? $clog2(DMAX) : 1;
  localparam logic [CW-1:0] LIM_F = CW'(DIV_FAST - 1);
  localparam logic [CW-1:0] LIM_S = CW'(DIV_SLOW - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? LIM_F : LIM_S;
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) cnt <= '0;
    else if (cnt == lim)      cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           cmp,
  output logic [RES-1:0] code,
  output logic [RES-1:0] decided,
  output logic           at_lsb
);
  localparam int IW = (RES > 2) ? $clog2(RES) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(RES - 1);

  logic [IW-1:0]  idx;
  logic [RES-1:0] mask;

  assign mask    = {{(RES-1){1'b0}}, 1'b1} << idx;
  assign decided = cmp ? code : (code & ~mask);
  assign at_lsb  = (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      idx  <= '0;
    end else if (load) begin
      code <= {1'b1, {(RES-1){1'b0}}};
      idx  <= TOP_IDX;
    end else if (step) begin
      if (at_lsb) begin
        code <= decided;
      end else begin
        code <= decided | (mask >> 1);
        idx  <= idx - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int RES          = 10,
  parameter int SAMPLE_TICKS = 4,
  parameter int DIV_FAST     = 2,
  parameter int DIV_SLOW     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_we,
  input  logic [7:0]      csr_wdata,
  output logic [7:0]      csr_rdata,
  input  logic            dat_hi_rd,
  output logic [7:0]      dat_hi,
  output logic [7:0]      dat_lo,
  input  logic            cmp_in,
  output logic [CH_W-1:0] chan_sel,
  output logic            samp_en,
  output logic [RES-1:0]  dac_code
);
  localparam int LO_W = RES - 8;
  localparam int SCW = (SAMPLE_TICKS > 2) ? $clog2(SAMPLE_TICKS) : 1;
  localparam logic [SCW-1:0] SAMP_LAST = SCW'(SAMPLE_TICKS - 1);

  sar_state_e     state;
  logic [SCW-1:0] samp_cnt;
  logic           eoc_q, rate_q, en_q;
  logic [CH_W-1:0] chan_q;
  logic [7:0]     hi_q;
  logic [LO_W-1:0] lo_q;

  logic start, stop, busy, tick, load, step, at_lsb, done_stb;
  logic [RES-1:0] decided;
  logic unused_wbits;

  assign unused_wbits = ^{csr_wdata[BIT_FLAG], csr_wdata[4:3]};
  assign start = csr_we && csr_wdata[BIT_EN];
  assign stop  = csr_we && !csr_wdata[BIT_EN];
  assign busy  = (state != ST_IDLE);
  assign load  = tick && (state == ST_SAMPLE) && (samp_cnt == SAMP_LAST) && !csr_we;
  assign step  = tick && (state == ST_SEARCH) && !csr_we;
  assign done_stb = step && at_lsb;

  sar_clkdiv #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk(clk), .rst(rst), .clear(start), .run(busy), .fast(rate_q), .tick(tick)
  );

  sar_search #(.RES(RES)) u_search (
    .clk(clk), .rst(rst), .load(load), .step(step), .cmp(cmp_in),
    .code(dac_code), .decided(decided), .at_lsb(at_lsb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      samp_cnt <= '0;
      samp_en  <= 1'b0;
      eoc_q    <= 1'b0;
      rate_q   <= 1'b0;
      en_q     <= 1'b0;
      chan_q   <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      if (csr_we) begin
        rate_q <= csr_wdata[BIT_RATE];
        en_q   <= csr_wdata[BIT_EN];
        chan_q <= csr_wdata[CH_W-1:0];
      end
      if (start) begin
        state    <= ST_SAMPLE;
        samp_cnt <= '0;
        samp_en  <= 1'b1;
      end else if (stop) begin
        state   <= ST_IDLE;
        samp_en <= 1'b0;
      end else begin
        case (state)
          ST_SAMPLE: if (tick) begin
            if (samp_cnt == SAMP_LAST) begin
              state   <= ST_SEARCH;
              samp_en <= 1'b0;
            end else begin
              samp_cnt <= samp_cnt + 1'b1;
            end
          end
          ST_SEARCH: if (done_stb) state <= ST_IDLE;
          default: ;
        endcase
      end
      if (done_stb)               eoc_q <= 1'b1;
      else if (start || dat_hi_rd) eoc_q <= 1'b0;
      if (done_stb) begin
        hi_q <= decided[RES-1 -: 8];
        lo_q <= decided[LO_W-1:0];
      end
    end
  end

  assign csr_rdata = {eoc_q, rate_q, en_q, 2'b00, chan_q};
  assign chan_sel  = chan_q;
  assign dat_hi    = hi_q;
  assign dat_lo    = 8'(lo_q);
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int RES = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           csr_we,
  input logic [7:0]     csr_wdata,
  input logic [7:0]     csr_rdata,
  input logic           dat_hi_rd,
  input logic [7:0]     dat_hi,
  input logic [7:0]     dat_lo,
  input logic [2:0]     chan_sel,
  input logic           samp_en,
  input logic [RES-1:0] dac_code,
  input logic           done
);
  assert_start_closes_R3: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_wdata[5]) |=> (samp_en && !csr_rdata[7]));

  assert_switch_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
    samp_en |-> csr_rdata[5]);

  assert_first_trial_msb_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(samp_en) && csr_rdata[5]) |-> (dac_code == {1'b1, {(RES-1){1'b0}}}));

  assert_flag_after_sampling_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(csr_rdata[7]) |-> !samp_en);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (dat_hi_rd && !done) |=> !csr_rdata[7]);

  assert_chan_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !csr_we |=> $stable(chan_sel));

  assert_data_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(dat_hi) && $stable(dat_lo)));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
  .csr_rdata(csr_rdata), .dat_hi_rd(dat_hi_rd), .dat_hi(dat_hi),
  .dat_lo(dat_lo), .chan_sel(chan_sel), .samp_en(samp_en),
  .dac_code(dac_code), .done(done_stb)
);

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csr_we = 1'b0;
  logic [7:0] csr_wdata = 8'h00;
  logic [7:0] csr_rdata;
  logic       dat_hi_rd = 1'b0;
  logic [7:0] dat_hi, dat_lo;
  logic       cmp_in;
  logic [2:0] chan_sel;
  logic       samp_en;
  logic [9:0] dac_code;
  logic [9:0] vin = 10'h000;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [9:0] prev_res = 10'h000;

  localparam logic [13:0] VEC [8] = '{
    {1'b1, 3'd2, 10'h2C8}, {1'b0, 3'd5, 10'h000},
    {1'b1, 3'd7, 10'h3FF}, {1'b0, 3'd0, 10'h200},
    {1'b1, 3'd1, 10'h1FF}, {1'b0, 3'd3, 10'h155},
    {1'b1, 3'd6, 10'h2AA}, {1'b0, 3'd4, 10'h001}
  };
  localparam logic [7:0] SEQ_B2 [8] = '{
    8'h80, 8'hC0, 8'hA0, 8'hB0, 8'hB8, 8'hB4, 8'hB2, 8'hB3
  };

  always #2.5 clk = ~clk;
  assign cmp_in = (vin >= dac_code);

  sar_adc_ctrl u_sar_adc_ctrl (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .dat_hi_rd(dat_hi_rd), .dat_hi(dat_hi),
    .dat_lo(dat_lo), .cmp_in(cmp_in), .chan_sel(chan_sel),
    .samp_en(samp_en), .dac_code(dac_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csr_write(input logic [7:0] d);
    csr_we = 1'b1; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic read_hi();
    dat_hi_rd = 1'b1;
    @(negedge clk);
    dat_hi_rd = 1'b0;
  endtask

  function automatic int trial(input int v, input int i);
    int c = 0;
    for (int k = 0; k < i; k++) begin
      int t = c | (1 << (9 - k));
      if (v >= t) c = t;
    end
    return c | (1 << (9 - i));
  endfunction

  task automatic convert(input logic spd, input logic [2:0] ch, input logic [9:0] v);
    int d = spd ? 2 : 4;
    vin = v;
    csr_write({1'b0, spd, 1'b1, 2'b00, ch});
    chk("R3 switch closed after start", samp_en, 1);
    chk("R3 flag cleared by start", csr_rdata[7], 0);
    chk("R2 channel select", chan_sel, ch);
    wait_n(4 * d - 1);
    chk("R3 switch still closed", samp_en, 1);
    chk("R7 data held during conversion", {dat_hi, dat_lo[1:0]}, prev_res);
    wait_n(1);
    chk("R3 switch open after 4 periods", samp_en, 0);
    chk("R5 first trial code", dac_code, 10'h200);
    if (v == 10'h2C8) chk("R6 8-bit trial 0", dac_code[9:2], SEQ_B2[0]);
    for (int i = 1; i < 10; i++) begin
      wait_n(d);
      chk("R6 trial code", dac_code, trial(v, i));
      if (v == 10'h2C8 && i < 8) chk("R6 8-bit trial", dac_code[9:2], SEQ_B2[i]);
    end
    wait_n(d - 1);
    chk("R4 flag not yet set", csr_rdata[7], 0);
    wait_n(1);
    chk("R4 flag set after 14 periods", csr_rdata[7], 1);
    chk("R7 high data", dat_hi, v[9:2]);
    chk("R7 low data", dat_lo, {6'b0, v[1:0]});
    prev_res = v;
    wait_n(3);
    chk("R8 flag held until read", csr_rdata[7], 1);
    read_hi();
    chk("R8 read clears flag", csr_rdata[7], 0);
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    chk("R1 status after reset", csr_rdata, 0);
    chk("R1 switch open after reset", samp_en, 0);
    chk("R1 trial code after reset", dac_code, 0);
    chk("R1 data after reset", {dat_hi, dat_lo}, 0);

    // R2 / R9: reserved bits ignored, enable clear starts nothing
    csr_write(8'h9A);
    chk("R2 status layout", csr_rdata, 8'h02);
    chk("R2 channel 2 selected", chan_sel, 3'd2);
    for (int i = 0; i < 64; i++) begin
      if (samp_en) chk("R9 no sampling while disabled", samp_en, 0);
      wait_n(1);
    end
    chk("R9 no flag while disabled", csr_rdata[7], 0);
    csr_write(8'h47);
    chk("R2 rate bit readback", csr_rdata, 8'h47);

    foreach (VEC[j]) convert(VEC[j][13], VEC[j][12:10], VEC[j][9:0]);

    // R9: abort during search
    begin
      logic [9:0] held;
      vin = 10'h123;
      csr_write(8'h61);
      wait_n(12);
      csr_write(8'h01);
      chk("R9 abort opens switch", samp_en, 0);
      held = dac_code;
      wait_n(40);
      chk("R9 no flag after abort", csr_rdata[7], 0);
      chk("R9 data unchanged after abort", {dat_hi, dat_lo[1:0]}, prev_res);
      chk("R9 trial code unchanged after abort", dac_code, held);
    end

    // R10: restart during search with new rate and channel
    vin = 10'h0F0;
    csr_write(8'h20);
    wait_n(28);
    convert(1'b1, 3'd3, 10'h30F);
    // R10: restart during sampling
    vin = 10'h011;
    csr_write(8'h65);
    wait_n(3);
    convert(1'b0, 3'd6, 10'h3C3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule